// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a time-of-day and calendar counter that answers at the eight highest byte addresses of a memory space. Every address below that window goes to an external RAM array through a plain decode. Both regions use the same chip-enable, write-enable, output-enable, address and data signals. The clock holds seconds, minutes, hours (24-hour), day of week, date, month, a two-digit year and a separate century, all in packed BCD. A synchronous one-cycle pulse, arriving once a second, advances them. Month lengths and leap years are applied on their own. Bit 7 of the day register always reports the battery status and cannot be written.

Bus writes are synchronous. A write is taken in the first cycle in which chip enable and write enable are both active, which is the cycle in which the later of the two arrives. Reads are combinational from the address. A control state machine has three states: RUN, FREEZE and HALT. In RUN, reads and writes go to the live counters. FREEZE serves reads from a snapshot while counting goes on behind it. HALT stops the counters and collects writes in a staging set. Clearing the halt bit copies the whole staging set into the counters in a single cycle.

The transitions are all triggered by a write to the control register. With the halt bit set, RUN or FREEZE goes to HALT (ENTER_HALT). With only the freeze bit set, RUN or FREEZE goes to FREEZE and takes a snapshot (TAKE_SNAPSHOT). With both bits clear, FREEZE goes to RUN (RELEASE). With the halt bit clear, HALT goes to RUN or to FREEZE (COMMIT): the staged values are loaded, and when the freeze bit is set they are also taken as the snapshot. A control write with the halt bit set while already in HALT stays in HALT (STAY_HALT).

Top module: `bcd_rtc_map`

## Requirements
- R1: An address of 0x1FF8 or above (the top eight of 13 address bits) selects the clock, and `ram_ce`/`ram_we` stay low. A lower address drives `ram_ce` = `ce` and `ram_we` = `ce & we`, and a read there returns `ram_rdata`.
- R2: The window offsets are as follows. Offset 0 is control: bit 7 halt, bit 6 freeze, bits 5:0 century. Offset 1 is seconds (bits 6:0), 2 minutes (6:0), 3 hours (5:0), 4 day (2:0) and 5 date (5:0). Offset 6 is month (4:0) and offset 7 is year (7:0). Written bits outside a field are dropped and read back as 0.
- R3: A write is taken only in the first cycle of a run of cycles with `ce` and `we` both high, using that cycle's `wdata`. Keeping both high does not write again.
- R4: `rdata` shows the addressed value while `ce & oe & ~we`, and 0x00 otherwise. A written value can be read from the cycle after the write.
- R5: Day-register bit 7 reads as the inverse of `batt_low`, whatever was written to it.
- R6: Each tick adds one second. Seconds and minutes roll from 59 to 00 and carry. Hours roll from 23 to 00 and carry into day and date.
- R7: Day goes from 7 back to 1. Date returns to 01 after the last day of the month and carries into the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by four and 28 otherwise.
- R8: Month rolls from 12 to 01 and increments the year. Year rolls from 99 to 00 and increments the century.
- R9: Writing control with bit 6 set and bit 7 clear enters FREEZE. Reads then return the time captured at that write, while ticks keep advancing the live counters. Control reads back 0x40 | century. Writing control with both bits clear shows the live time again.
- R10: Writing control with bit 7 set enters HALT, and the staging set starts as a copy of the time. Ticks are then ignored, and time writes and reads use the staging set. Writing control with bit 7 clear loads every staged field at once.
- R11: A tick that arrives in the same cycle as a write to any clock register is dropped. A tick during a RAM write is not dropped.
- R12: After reset the block is in RUN. Century is 20, month, date and day are 01, and the remaining fields are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| tick_1hz | input | 1 | One-cycle pulse per second |
| batt_low | input | 1 | Battery low indication |
| ram_ce | output | 1 | Enable to the RAM array below the window |
| ram_we | output | 1 | Write enable to the RAM array |
| ram_rdata | input | 8 | Read data from the RAM array |

## Verification
Every register in this block can be seen through a read port, so a wrong counter, staging or snapshot value shows up on `rdata` in the first cycle it is addressed. A bad rollover shows up one cycle after the tick that caused it. A wrong FSM state changes the control readback and the source of reads immediately. A state that drops or keeps ticks by mistake makes the seconds readback drift from the reference model within one tick.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
    localparam int NREG  = 8;
    localparam int FW    = 8;
    localparam int OFF_W = $clog2(NREG);

    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [OFF_W-1:0] OFF_SEC  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_MIN  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_HOUR = 3'd3;
    localparam logic [OFF_W-1:0] OFF_DAY  = 3'd4;
    localparam logic [OFF_W-1:0] OFF_DATE = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MON  = 3'd6;
    localparam logic [OFF_W-1:0] OFF_YEAR = 3'd7;

    typedef logic [NREG-1:0][FW-1:0] regfile_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FREEZE = 2'd1,
        ST_HALT   = 2'd2
    } rtc_state_e;

    // Bits kept for each field; the rest are dropped on write.
    function automatic logic [FW-1:0] field_mask(input logic [OFF_W-1:0] off);
        logic [FW-1:0] m;
        case (off)
            OFF_CTRL: m = 8'h3F;
            OFF_SEC:  m = 8'h7F;
            OFF_MIN:  m = 8'h7F;
            OFF_HOUR: m = 8'h3F;
            OFF_DAY:  m = 8'h07;
            OFF_DATE: m = 8'h3F;
            OFF_MON:  m = 8'h1F;
            default:  m = 8'hFF;
        endcase
        return m;
    endfunction

    // Next BCD value with wrap: returns {carry, value}.
    function automatic logic [FW:0] bcd_next(input logic [FW-1:0] v,
                                              input logic [FW-1:0] top,
                                              input logic [FW-1:0] base);
        logic [FW:0] r;
        if (v == top)
            r = {1'b1, base};
        else if (v[3:0] >= 4'd9)
            r = {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            r = {1'b0, v + 8'd1};
        return r;
    endfunction

    // Last BCD date of a month; leap when the BCD year is a multiple of 4.
    function automatic logic [FW-1:0] month_last(input logic [FW-1:0] mon,
                                                 input logic [FW-1:0] yr);
        logic [4:0]    mod_sum;
        logic [FW-1:0] last;
        mod_sum = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        case (mon)
            8'h02:                      last = (mod_sum[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
            default:                    last = 8'h31;
        endcase
        return last;
    endfunction
endpackage

// File: rtl/rtc_addr_decode.sv
`timescale 1ns/1ps
module rtc_addr_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              clk_wr,
    output logic              in_top,
    output logic [OFF_W-1:0]  off,
    output logic              ram_ce,
    output logic              ram_we
);
    localparam int TOP_BASE = (1 << ADDR_W) - NREG;

    logic wr_act;
    logic wr_act_q;

    assign wr_act = ce & we;
    assign in_top = (addr >= ADDR_W'(TOP_BASE));
    assign off    = addr[OFF_W-1:0];
    assign clk_wr = wr_act & ~wr_act_q & in_top;
    assign ram_ce = ce & ~in_top;
    assign ram_we = ram_ce & we;

    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_q <= 1'b0;
        else        wr_act_q <= wr_act;
    end
endmodule

// File: rtl/rtc_ctrl_fsm.sv
`timescale 1ns/1ps
module rtc_ctrl_fsm
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_wr,
    input  logic [OFF_W-1:0] off,
    input  logic [FW-1:0]    wdata,
    input  regfile_t         cnt,
    output rtc_state_e       state,
    output logic [NREG-1:0]  ld_mask,
    output regfile_t         ld_val,
    output logic             hold,
    output regfile_t         stg,
    output regfile_t         snp
);
    rtc_state_e state_q, state_d;
    regfile_t   stg_d, snp_d, merged;
    logic       ctrl_wr, field_wr, wr_halt, wr_frz;
    logic [FW-1:0] cen, fval;

    assign ctrl_wr  = clk_wr && (off == OFF_CTRL);
    assign field_wr = clk_wr && (off != OFF_CTRL);
    assign wr_halt  = wdata[7];
    assign wr_frz   = wdata[6];
    assign cen      = wdata & field_mask(OFF_CTRL);
    assign fval     = wdata & field_mask(off);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case (state_q)
                ST_RUN, ST_FREEZE: begin
                    if (wr_halt)     state_d = ST_HALT;    // ENTER_HALT
                    else if (wr_frz) state_d = ST_FREEZE;  // TAKE_SNAPSHOT
                    else             state_d = ST_RUN;     // RELEASE
                end
                ST_HALT: begin
                    if (!wr_halt) state_d = wr_frz ? ST_FREEZE : ST_RUN; // COMMIT
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Outputs: load requests, staging and snapshot updates
    always_comb begin
        ld_mask = '0;
        ld_val  = cnt;
        stg_d   = stg;
        if (field_wr) begin
            if (state_q == ST_HALT) begin
                stg_d[off] = fval;
            end else begin
                ld_mask[off] = 1'b1;
                ld_val[off]  = fval;
            end
        end
        if (ctrl_wr) begin
            unique case (state_q)
                ST_HALT: begin
                    stg_d[OFF_CTRL] = cen;
                    if (!wr_halt) begin
                        ld_mask = '1;
                        ld_val  = stg_d;
                    end
                end
                ST_RUN, ST_FREEZE: begin
                    if (wr_halt) begin
                        stg_d           = cnt;
                        stg_d[OFF_CTRL] = cen;
                    end else begin
                        ld_mask[OFF_CTRL] = 1'b1;
                        ld_val[OFF_CTRL]  = cen;
                    end
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NREG; i++)
            merged[i] = ld_mask[i] ? ld_val[i] : cnt[i];
        snp_d = (ctrl_wr && state_d == ST_FREEZE) ? merged : snp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
            snp <= '0;
        end else begin
            stg <= stg_d;
            snp <= snp_d;
        end
    end

    assign state = state_q;
    assign hold  = (state_q == ST_HALT) | clk_wr;
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter logic [FW-1:0] RST_CENTURY = 8'h20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            hold,
    input  logic [NREG-1:0] ld_mask,
    input  regfile_t        ld_val,
    output regfile_t        cnt
);
    localparam regfile_t RST_VAL = {8'h00, 8'h01, 8'h01, 8'h01,
                                    8'h00, 8'h00, 8'h00, RST_CENTURY};

    regfile_t cnt_q, cnt_d, loaded;
    logic [FW:0] r;
    logic        carry;

    for (genvar i = 0; i < NREG; i++) begin : g_load
        assign loaded[i] = ld_mask[i] ? ld_val[i] : cnt_q[i];
    end

    always_comb begin
        cnt_d = cnt_q;
        r     = '0;
        carry = 1'b0;
        if (|ld_mask) begin
            cnt_d = loaded;
        end else if (tick && !hold) begin
            r = bcd_next(cnt_q[OFF_SEC], 8'h59, 8'h00);
            cnt_d[OFF_SEC] = r[FW-1:0];
            carry = r[FW];
            if (carry) begin
                r = bcd_next(cnt_q[OFF_MIN], 8'h59, 8'h00);
                cnt_d[OFF_MIN] = r[FW-1:0];
                carry = r[FW];
            end
            if (carry) begin
                r = bcd_next(cnt_q[OFF_HOUR], 8'h23, 8'h00);
                cnt_d[OFF_HOUR] = r[FW-1:0];
                carry = r[FW];
            end
            if (carry) begin
                r = bcd_next(cnt_q[OFF_DAY], 8'h07, 8'h01);
                cnt_d[OFF_DAY] = r[FW-1:0];
                r = bcd_next(cnt_q[OFF_DATE],
                             month_last(cnt_q[OFF_MON], cnt_q[OFF_YEAR]), 8'h01);
                cnt_d[OFF_DATE] = r[FW-1:0];
                carry = r[FW];
            end
            if (carry) begin
                r = bcd_next(cnt_q[OFF_MON], 8'h12, 8'h01);
                cnt_d[OFF_MON] = r[FW-1:0];
                carry = r[FW];
            end
            if (carry) begin
                r = bcd_next(cnt_q[OFF_YEAR], 8'h99, 8'h00);
                cnt_d[OFF_YEAR] = r[FW-1:0];
                carry = r[FW];
            end
            if (carry) begin
                r = bcd_next(cnt_q[OFF_CTRL], 8'h39, 8'h00);
                cnt_d[OFF_CTRL] = r[FW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bcd_rtc_map.sv
`timescale 1ns/1ps
module bcd_rtc_map
    import rtc_pkg::*;
#(
    parameter int            ADDR_W      = 13,
    parameter logic [FW-1:0] RST_CENTURY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FW-1:0]     wdata,
    output logic [FW-1:0]     rdata,
    input  logic              tick_1hz,
    input  logic              batt_low,
    output logic              ram_ce,
    output logic              ram_we,
    input  logic [FW-1:0]     ram_rdata
);
    logic             clk_wr, in_top, hold;
    logic [OFF_W-1:0] off;
    logic [NREG-1:0]  ld_mask;
    regfile_t         ld_val, cnt, stg, snp, src;
    rtc_state_e       state;
    logic [FW-1:0]    val;

    rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .clk_wr(clk_wr), .in_top(in_top), .off(off),
        .ram_ce(ram_ce), .ram_we(ram_we)
    );

    rtc_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clk_wr(clk_wr), .off(off), .wdata(wdata),
        .cnt(cnt), .state(state), .ld_mask(ld_mask), .ld_val(ld_val),
        .hold(hold), .stg(stg), .snp(snp)
    );

    rtc_calendar #(.RST_CENTURY(RST_CENTURY)) u_cal (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold(hold),
        .ld_mask(ld_mask), .ld_val(ld_val), .cnt(cnt)
    );

    // Read path: source set chosen by state
    always_comb begin
        unique case (state)
            ST_HALT:   src = stg;
            ST_FREEZE: src = snp;
            default:   src = cnt;
        endcase
        val = src[off];
        if (off == OFF_CTRL) val[7:6] = {state == ST_HALT, state == ST_FREEZE};
        if (off == OFF_DAY)  val[7]   = ~batt_low;
        if (ce && oe && !we) rdata = in_top ? val : ram_rdata;
        else                 rdata = '0;
    end
endmodule

// File: rtl/rtc_checks.sv
`timescale 1ns/1ps
module rtc_checks
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we,
    input logic              oe,
    input logic [ADDR_W-1:0] addr,
    input logic [FW-1:0]     rdata,
    input logic              batt_low,
    input logic              ram_ce,
    input logic              ram_we,
    input logic              advance,
    input rtc_state_e        state,
    input logic [NREG-1:0]   ld_mask,
    input regfile_t          cnt
);
    localparam logic [ADDR_W-1:0] TOPB    = ADDR_W'((1 << ADDR_W) - NREG);
    localparam logic [ADDR_W-1:0] DAY_ADR = TOPB + ADDR_W'(4);

    assert_ram_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && addr >= TOPB) |-> (!ram_ce && !ram_we));

    assert_bus_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce || !oe || we) |-> (rdata == 8'h00));

    assert_batt_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && oe && !we && addr == DAY_ADR) |-> (rdata[7] == !batt_low));

    assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(advance) && $past(cnt[1]) == 8'h59) |-> (cnt[1] == 8'h00));

    assert_halt_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && ld_mask == '0) |=> $stable(cnt));
endmodule

bind bcd_rtc_map rtc_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .oe(oe), .addr(addr),
    .rdata(rdata), .batt_low(batt_low), .ram_ce(ram_ce), .ram_we(ram_we),
    .advance(tick_1hz && !hold && (ld_mask == '0)),
    .state(state), .ld_mask(ld_mask), .cnt(cnt)
);

// File: tb/tb_bcd_rtc_map.sv
`timescale 1ns/1ps
module tb_bcd_rtc_map;
    localparam int TOPB = 8184;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 0, we = 0, oe = 0, tick_1hz = 0, batt_low = 0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, ram_rdata;
    logic        ram_ce, ram_we;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;
    assign ram_rdata = addr[7:0] ^ 8'hA5;

    bcd_rtc_map dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .oe(oe), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_1hz(tick_1hz), .batt_low(batt_low),
        .ram_ce(ram_ce), .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    // Reference model: fields as BCD bytes, state 0 run, 1 freeze, 2 halt
    logic [7:0] mc[8], ms[8], mp[8];
    int         mst;
    bit         mwq;

    function automatic logic [7:0] fmask(int o);
        case (o)
            0: return 8'h3F; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h3F;
            4: return 8'h07; 5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction
    function automatic int b2i(logic [7:0] v); return v[7:4] * 10 + v[3:0]; endfunction
    function automatic logic [7:0] i2b(int i); return {4'(i / 10), 4'(i % 10)}; endfunction
    function automatic int mlast(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        mc[0] = 8'h20; mc[1] = 0; mc[2] = 0; mc[3] = 0;
        mc[4] = 8'h01; mc[5] = 8'h01; mc[6] = 8'h01; mc[7] = 0;
        for (int i = 0; i < 8; i++) begin ms[i] = 0; mp[i] = 0; end
        mst = 0; mwq = 0;
    endtask

    task automatic model_tick();
        int v, mo, yr;
        v = b2i(mc[1]) + 1;
        if (v < 60) begin mc[1] = i2b(v); return; end
        mc[1] = 0;
        v = b2i(mc[2]) + 1;
        if (v < 60) begin mc[2] = i2b(v); return; end
        mc[2] = 0;
        v = b2i(mc[3]) + 1;
        if (v < 24) begin mc[3] = i2b(v); return; end
        mc[3] = 0;
        mc[4] = (mc[4] == 7) ? 8'h01 : mc[4] + 1;
        mo = b2i(mc[6]); yr = b2i(mc[7]);
        v = b2i(mc[5]) + 1;
        if (v <= mlast(mo, yr)) begin mc[5] = i2b(v); return; end
        mc[5] = 8'h01;
        if (mo < 12) begin mc[6] = i2b(mo + 1); return; end
        mc[6] = 8'h01;
        if (yr < 99) begin mc[7] = i2b(yr + 1); return; end
        mc[7] = 0;
        v = b2i(mc[0]) + 1;
        mc[0] = (v > 39) ? 8'h00 : i2b(v);
    endtask

    task automatic model_edge(logic c, logic w, logic [12:0] a, logic [7:0] d, logic t);
        bit act, wp, h, f;
        int o;
        logic [7:0] cen;
        act = c && w; wp = act && !mwq; mwq = act;
        o = int'(a[2:0]); h = d[7]; f = d[6]; cen = d & 8'h3F;
        if (wp && a >= TOPB) begin
            if (o != 0) begin
                if (mst == 2) ms[o] = d & fmask(o);
                else          mc[o] = d & fmask(o);
            end else if (mst == 2) begin
                ms[0] = cen;
                if (!h) begin
                    for (int i = 0; i < 8; i++) mc[i] = ms[i];
                    if (f) begin for (int i = 0; i < 8; i++) mp[i] = mc[i]; mst = 1; end
                    else mst = 0;
                end
            end else if (h) begin
                for (int i = 0; i < 8; i++) ms[i] = mc[i];
                ms[0] = cen; mst = 2;
            end else begin
                mc[0] = cen;
                if (f) begin for (int i = 0; i < 8; i++) mp[i] = mc[i]; mst = 1; end
                else mst = 0;
            end
        end else if (t && mst != 2) begin
            model_tick();
        end
    endtask

    function automatic logic [7:0] model_read(logic c, logic w, logic o, logic [12:0] a);
        logic [7:0] v;
        int k;
        if (!(c && o && !w)) return 8'h00;
        if (a < TOPB) return a[7:0] ^ 8'hA5;
        k = int'(a[2:0]);
        if (mst == 2)      v = ms[k];
        else if (mst == 1) v = mp[k];
        else               v = mc[k];
        if (k == 0) v[7:6] = {mst == 2, mst == 1};
        if (k == 4) v[7] = !batt_low;
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic step(logic c, logic w, logic o, logic [12:0] a, logic [7:0] d,
                        logic t, int exp, string tag);
        logic [7:0] er;
        logic rce, rwe;
        @(negedge clk);
        ce = c; we = w; oe = o; addr = a; wdata = d; tick_1hz = t;
        #5;
        er  = model_read(c, w, o, a);
        rce = c && (a < TOPB);
        rwe = rce && w;
        check(rdata == er, tag, rdata, er);
        check({ram_ce, ram_we} == {rce, rwe}, "R1 ram strobes",
              {6'd0, ram_ce, ram_we}, {6'd0, rce, rwe});
        if (exp >= 0) check(rdata == exp[7:0], tag, rdata, exp[7:0]);
        @(posedge clk);
        model_edge(c, w, a, d, t);
    endtask

    task automatic idle(int n, string tag);
        repeat (n) step(0, 0, 0, addr, 8'h00, 0, -1, tag);
    endtask
    task automatic wr(logic [12:0] a, logic [7:0] d, string tag);
        step(1, 1, 0, a, d, 0, -1, tag);
        step(0, 0, 0, a, 8'h00, 0, -1, tag);
    endtask
    task automatic rd(logic [12:0] a, int exp, string tag);
        step(1, 0, 1, a, 8'h00, 0, exp, tag);
    endtask
    task automatic ticks(int n, string tag);
        repeat (n) step(0, 0, 0, addr, 8'h00, 1, -1, tag);
    endtask

    task automatic set_time(logic [7:0] cen, logic [7:0] yr, logic [7:0] mon,
                            logic [7:0] dt, logic [7:0] dy, logic [7:0] hr,
                            logic [7:0] mi, logic [7:0] se, string tag);
        wr(13'(TOPB), 8'h80 | cen, tag);
        wr(13'(TOPB + 1), se, tag); wr(13'(TOPB + 2), mi, tag);
        wr(13'(TOPB + 3), hr, tag); wr(13'(TOPB + 4), dy, tag);
        wr(13'(TOPB + 5), dt, tag); wr(13'(TOPB + 6), mon, tag);
        wr(13'(TOPB + 7), yr, tag);
        wr(13'(TOPB), cen, tag);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R12 reset values, R5 flag, R2 layout
        rd(13'(TOPB + 0), 8'h20, "R12 century");
        rd(13'(TOPB + 1), 8'h00, "R12 seconds");
        rd(13'(TOPB + 3), 8'h00, "R12 hours");
        rd(13'(TOPB + 4), 8'h81, "R12 day with R5 flag");
        rd(13'(TOPB + 5), 8'h01, "R12 date");
        rd(13'(TOPB + 6), 8'h01, "R12 month");
        rd(13'(TOPB + 7), 8'h00, "R12 year");

        // R1 RAM pass-through, R4 gating
        step(1, 1, 0, 13'h0100, 8'h3C, 0, -1, "R1 ram write");
        idle(1, "R1");
        rd(13'h0100, 8'hA5, "R1 ram read");
        rd(13'(TOPB - 1), 8'h52, "R1 highest ram address");
        step(1, 0, 0, 13'(TOPB + 4), 8'h00, 0, 8'h00, "R4 oe low");
        step(1, 1, 1, 13'h0200, 8'h00, 0, 8'h00, "R4 we high");
        idle(1, "R4");

        // R6 simple tick
        ticks(1, "R6 tick");
        rd(13'(TOPB + 1), 8'h01, "R6 one second");

        // R10 halt: staging, ignored ticks, joint load
        wr(13'(TOPB), 8'hA0, "R10 enter halt");
        rd(13'(TOPB), 8'hA0, "R10 control readback");
        wr(13'(TOPB + 1), 8'h59, "R10"); wr(13'(TOPB + 2), 8'h59, "R10");
        wr(13'(TOPB + 3), 8'h23, "R10"); wr(13'(TOPB + 4), 8'h07, "R10");
        wr(13'(TOPB + 5), 8'h31, "R10"); wr(13'(TOPB + 6), 8'h12, "R10");
        wr(13'(TOPB + 7), 8'h99, "R10");
        ticks(3, "R10 ticks in halt");
        rd(13'(TOPB + 1), 8'h59, "R10 staged seconds held");
        wr(13'(TOPB), 8'h20, "R10 commit");
        rd(13'(TOPB + 2), 8'h59, "R10 committed minutes");
        rd(13'(TOPB + 7), 8'h99, "R10 committed year");

        // R6 R7 R8 full rollover
        ticks(1, "R8 rollover tick");
        rd(13'(TOPB + 1), 8'h00, "R6 sec wrap");
        rd(13'(TOPB + 2), 8'h00, "R6 min wrap");
        rd(13'(TOPB + 3), 8'h00, "R6 hour wrap");
        rd(13'(TOPB + 4), 8'h81, "R7 day 7 to 1");
        rd(13'(TOPB + 5), 8'h01, "R7 date wrap");
        rd(13'(TOPB + 6), 8'h01, "R8 month wrap");
        rd(13'(TOPB + 7), 8'h00, "R8 year wrap");
        rd(13'(TOPB + 0), 8'h21, "R8 century increment");

        // R7 month lengths and leap years
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, "R7 set");
        ticks(1, "R7");
        rd(13'(TOPB + 5), 8'h29, "R7 leap feb 29");
        rd(13'(TOPB + 6), 8'h02, "R7 leap month kept");
        rd(13'(TOPB + 4), 8'h84, "R7 day step");
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59, "R7 set");
        ticks(1, "R7");
        rd(13'(TOPB + 5), 8'h01, "R7 after feb 29");
        rd(13'(TOPB + 6), 8'h03, "R7 march");
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, "R7 set");
        ticks(1, "R7");
        rd(13'(TOPB + 5), 8'h01, "R7 common feb 28 wrap");
        rd(13'(TOPB + 6), 8'h03, "R7 common march");
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, "R7 set");
        ticks(1, "R7");
        rd(13'(TOPB + 5), 8'h01, "R7 april 30 wrap");
        rd(13'(TOPB + 6), 8'h05, "R7 may");

        // R9 freeze
        set_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30, "R9 set");
        wr(13'(TOPB), 8'h60, "R9 enter freeze");
        rd(13'(TOPB), 8'h60, "R9 control readback");
        ticks(5, "R9 ticks while frozen");
        rd(13'(TOPB + 1), 8'h30, "R9 frozen seconds");
        wr(13'(TOPB), 8'h20, "R9 release");
        rd(13'(TOPB + 1), 8'h35, "R9 live seconds advanced");

        // R3 write taken once on the later strobe
        step(1, 0, 0, 13'(TOPB + 1), 8'h00, 0, -1, "R3 ce first");
        step(1, 1, 0, 13'(TOPB + 1), 8'h12, 0, -1, "R3 we arrives");
        step(1, 1, 0, 13'(TOPB + 1), 8'h34, 0, -1, "R3 held");
        idle(1, "R3");
        rd(13'(TOPB + 1), 8'h12, "R3 single write");

        // R11 tick dropped on clock write, kept on RAM write
        step(1, 1, 0, 13'(TOPB + 1), 8'h10, 1, -1, "R11 write with tick");
        idle(1, "R11");
        rd(13'(TOPB + 1), 8'h10, "R11 tick dropped");
        step(1, 1, 0, 13'h0040, 8'h00, 1, -1, "R11 ram write with tick");
        idle(1, "R11");
        rd(13'(TOPB + 1), 8'h11, "R11 tick kept");

        // R5 battery flag, R2 field masking
        wr(13'(TOPB + 4), 8'h85, "R5 day write");
        rd(13'(TOPB + 4), 8'h85, "R5 good battery");
        batt_low = 1'b1;
        rd(13'(TOPB + 4), 8'h05, "R5 low battery");
        batt_low = 1'b0;
        wr(13'(TOPB + 3), 8'hFF, "R2 hour write");
        rd(13'(TOPB + 3), 8'h3F, "R2 hour masked");
        wr(13'(TOPB + 6), 8'hEB, "R2 month write");
        rd(13'(TOPB + 6), 8'h0B, "R2 month masked");
        wr(13'(TOPB + 3), 8'h10, "R2 restore");
        wr(13'(TOPB + 6), 8'h06, "R2 restore");
        rd(13'(TOPB + 3), 8'h10, "R2 hour restored");

        idle(2, "end");
        report();
        $finish;
    end
endmodule